// File: doc/BRIEF.md
# Phase-Accumulator Oscillator with Toggle and Pulse Output

This block is a numerically controlled oscillator. On every enabled clock a programmable increment is added to a 20-bit phase accumulator. The carry out of that addition is the overflow event, and the wrapped sum stays in the accumulator. The overflow drives a waveform generator that works in one of two ways. In toggle mode the output level flips on each overflow, which gives a square wave with a 50% duty cycle while the increment stays fixed. In pulse mode each overflow starts an active pulse whose length is a power of two clocks, chosen by a 3-bit code. A polarity stage at the output decides which pin level counts as active.

Each overflow sets a sticky event flag that software clears. A change of polarity while interrupts are enabled also sets the flag, so software sees the output edge that the change produces. The interrupt request is the flag gated by the interrupt enable and the block enable. The output frequency is f_clk * inc / 2^20: halved in toggle mode, and as a pulse rate in pulse mode.

Top module: `nco_out_stage`

## Requirements
- R1: While the reset is asserted and after it is released, with all inputs at zero, nco_o, flag_o and irq_o are all 0.
- R2: While en_i is 1, each clock adds inc_i to the 20-bit accumulator modulo 2^20. An overflow occurs on the clock where the true sum reaches 2^20 or more, and the remainder is kept, so overflows are spaced according to the long-run rate inc_i/2^20.
- R3: With mode_i = 0 (toggle mode), the internal output state flips on the same clock edge that stores an overflowing sum. With a constant increment of 2^18 the output is high for exactly half of any 64-cycle window.
- R4: With mode_i = 1 (pulse mode), the internal state becomes active on the clock edge of an overflow and stays active for exactly 2^n clocks, where n is the value of pw_sel_i (0 to 7). It then returns inactive.
- R5: nco_o equals the internal state XOR pol_i, so the inactive level is pol_i and the active level is NOT pol_i.
- R6: Every overflow sets flag_o on that clock edge. flag_o stays 1 until a clock with flag_clr_i = 1. A set in the same clock as a clear wins.
- R7: When en_i and irq_en_i are 1, a clock on which pol_i differs from its value on the previous clock sets flag_o. With irq_en_i = 0, a polarity change leaves flag_o untouched.
- R8: irq_o is 1 exactly when flag_o, irq_en_i and en_i are all 1.
- R9: While en_i is 0, the accumulator holds its value, nco_o sits at the inactive level pol_i, and flag_o is not set. After re-enabling, the accumulation resumes from the held phase.
- R10: Asserting rst_n low clears the outputs at once, without a clock. After rst_n rises, the block stays in reset for two more rising clock edges and then starts updating on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| mode_i | input | 1 | 0 = toggle mode, 1 = pulse mode |
| pol_i | input | 1 | Output polarity; the inactive level of nco_o |
| pw_sel_i | input | 3 | Pulse-width code n; the pulse lasts 2^n clocks |
| inc_i | input | 20 | Phase increment |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the event flag |
| nco_o | output | 1 | Oscillator output after the polarity stage |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The hardest case to reach from the ports is the exact edge of a long pulse. A width of 2^7 clocks shows its end only when no overflow arrives during that pulse. The stimulus therefore sweeps every width code under both polarities with an increment of 2^12, which gives 256 clocks between overflows. Each pulse then ends well before the next overflow, and the first full pulse of each setting is measured directly. A cycle-by-cycle arithmetic model of the accumulator, output state and flag runs alongside these sweeps. It covers the wrapped remainder of a non-power-of-two increment, the hold while disabled, the polarity-triggered flag, and release from an asynchronous reset while the increment is already running.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_ACC_W = 20;
  localparam int unsigned NCO_PW_W  = 3;

  typedef enum logic {
    MODE_TOGGLE = 1'b0,
    MODE_PULSE  = 1'b1
  } nco_mode_e;
endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             ovf_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum_w;

  always_comb begin
    sum_w = {1'b0, acc_q} + {1'b0, inc_i};
    acc_d = acc_q;
    ovf_o = 1'b0;
    if (en_i) begin
      acc_d = sum_w[ACC_W-1:0];
      ovf_o = sum_w[ACC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end

  // R9: the phase is frozen while the block is off
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> acc_q == $past(acc_q));

  // R2: an overflow leaves a remainder below the increment
  p_wrap_rem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> acc_q < $past(inc_i));
endmodule

// File: rtl/nco_wave_gen.sv
module nco_wave_gen
  import nco_pkg::*;
#(
  parameter int unsigned PW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  nco_mode_e       mode_i,
  input  logic [PW_W-1:0] pw_sel_i,
  input  logic            ovf_i,
  output logic            state_o
);
  localparam int unsigned CNT_W = (1 << PW_W) - 1;

  logic             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   width_w;
  logic [CNT_W:0]   width_m1_w;
  logic [CNT_W-1:0] load_w;

  always_comb begin
    width_w    = (CNT_W+1)'(1) << pw_sel_i;
    width_m1_w = width_w - (CNT_W+1)'(1);
    load_w     = width_m1_w[CNT_W-1:0];
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = 1'b0;
      cnt_d   = '0;
    end else if (mode_i == MODE_TOGGLE) begin
      cnt_d = '0;
      if (ovf_i) state_d = ~state_q;
    end else if (ovf_i) begin
      state_d = 1'b1;
      cnt_d   = load_w;
    end else if (state_q) begin
      if (cnt_q == '0) state_d = 1'b0;
      else             cnt_d   = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R3: toggle mode flips the state on each overflow
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == MODE_TOGGLE && ovf_i) |=> state_q != $past(state_q));

  // R4: pulse mode goes active on the overflow edge
  p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == MODE_PULSE && ovf_i) |=> state_q);

  // R4: no width count pending without an active pulse
  p_cnt_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q |-> cnt_q == '0);

  // R9: disabled means inactive
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !state_q);
endmodule

// File: rtl/nco_irq_ctrl.sv
module nco_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ovf_i,
  input  logic pol_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic pol_q;
  logic flag_q, flag_d;
  logic pol_chg_w;
  logic set_w;

  always_comb begin
    pol_chg_w = pol_i ^ pol_q;
    set_w     = en_i & (ovf_i | (irq_en_i & pol_chg_w));
    flag_d    = set_w | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pol_q  <= pol_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i & en_i;

  // R6: overflow raises the flag
  p_ovf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> flag_q);

  // R6: flag survives until cleared
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R7: a polarity change with interrupts on raises the flag
  p_pol_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && irq_en_i && pol_i != pol_q) |=> flag_q);

  // R9: nothing new is flagged while off
  p_off_noset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !flag_q) |=> !flag_q);

  // R8: the request never appears without the flag
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);
endmodule

// File: rtl/nco_out_stage.sv
module nco_out_stage
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = NCO_ACC_W,
  parameter int unsigned PW_W  = NCO_PW_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             pol_i,
  input  logic [PW_W-1:0]  pw_sel_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  output logic             nco_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic      rst_sync_n;
  logic      ovf_w;
  logic      state_w;
  nco_mode_e mode_w;

  assign mode_w = nco_mode_e'(mode_i);

  nco_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (en_i),
    .inc_i (inc_i),
    .ovf_o (ovf_w)
  );

  nco_wave_gen #(.PW_W(PW_W)) u_wave (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_i),
    .mode_i   (mode_w),
    .pw_sel_i (pw_sel_i),
    .ovf_i    (ovf_w),
    .state_o  (state_w)
  );

  nco_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_i),
    .ovf_i    (ovf_w),
    .pol_i    (pol_i),
    .irq_en_i (irq_en_i),
    .clr_i    (flag_clr_i),
    .flag_o   (flag_o),
    .irq_o    (irq_o)
  );

  assign nco_o = state_w ^ pol_i;

  // R5: a disabled block drives the inactive level
  p_inactive_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> nco_o == pol_i);
endmodule

// File: tb/tb_nco_out_stage.sv
module tb_nco_out_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0, mode_i = 1'b0, pol_i = 1'b0;
  logic [2:0]  pw_sel_i = '0;
  logic [19:0] inc_i = '0;
  logic        irq_en_i = 1'b0, flag_clr_i = 1'b0;
  logic        nco_o, flag_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  nco_out_stage dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i), .pol_i(pol_i),
    .pw_sel_i(pw_sel_i), .inc_i(inc_i), .irq_en_i(irq_en_i),
    .flag_clr_i(flag_clr_i), .nco_o(nco_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // arithmetic reference built from the requirements
  logic [1:0]  m_sync;
  logic [19:0] m_acc;
  logic        m_st, m_flag, m_polq;
  int          m_left;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '0; m_acc <= '0; m_st <= 1'b0; m_flag <= 1'b0;
      m_polq <= 1'b0; m_left <= 0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (m_sync[1]) begin
        logic [20:0] s;
        logic ov;
        s  = {1'b0, m_acc} + {1'b0, inc_i};
        ov = en_i && s[20];
        if (en_i) m_acc <= s[19:0];
        if (!en_i) begin
          m_st <= 1'b0; m_left <= 0;
        end else if (!mode_i) begin
          m_left <= 0;
          if (ov) m_st <= ~m_st;
        end else if (ov) begin
          m_st <= 1'b1; m_left <= (1 << pw_sel_i) - 1;
        end else if (m_st) begin
          if (m_left == 0) m_st <= 1'b0;
          else m_left <= m_left - 1;
        end
        m_flag <= (en_i && (ov || (irq_en_i && pol_i != m_polq))) ||
                  (m_flag && !flag_clr_i);
        m_polq <= pol_i;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(cur_req, nco_o,  m_st ^ pol_i, "nco_o");
    check(cur_req, flag_o, m_flag, "flag_o");
    check("R8",    irq_o,  m_flag & irq_en_i & en_i, "irq_o");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  // R4: length of the first complete active pulse
  task automatic measure_pulse(input int exp_len);
    int len = 0;
    int guard = 0;
    while (nco_o == pol_i && guard < 600) begin step(1); guard++; end
    while (nco_o != pol_i && guard < 1200) begin step(1); len++; guard++; end
    check_int("R4", len, exp_len, "pulse width");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    check("R1", nco_o, 1'b0, "nco_o in reset");
    check("R1", flag_o, 1'b0, "flag_o in reset");
    rst_n = 1'b1;
    step(4);
    check("R1", flag_o, 1'b0, "flag_o after release");

    // R2/R3: toggle mode, odd increment keeps a remainder
    cur_req = "R2";
    flag_clr_i = 1'b1; en_i = 1'b1; inc_i = 20'h3_3333;
    step(300);
    cur_req = "R3";
    inc_i = 20'h4_0000;
    step(20);
    begin
      int hi = 0;
      for (int i = 0; i < 64; i++) begin step(1); if (nco_o) hi++; end
      check_int("R3", hi, 32, "high cycles in 64");
    end

    // R4/R5: pulse-width sweep under both polarities
    mode_i = 1'b1; inc_i = 20'h0_1000;
    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < 8; w++) begin
        cur_req = (p == 0) ? "R4" : "R5";
        en_i = 1'b0; pol_i = p[0]; pw_sel_i = w[2:0];
        step(2);
        check("R5", nco_o, p[0], "inactive level");
        en_i = 1'b1;
        measure_pulse(1 << w);
        step(40);
      end
    end

    // R9: disable holds phase, idles output, sets nothing
    cur_req = "R9";
    pol_i = 1'b0; pw_sel_i = 3'd2; inc_i = 20'h0_7123;
    step(97);
    flag_clr_i = 1'b1; en_i = 1'b0;
    step(1);
    flag_clr_i = 1'b0;
    for (int i = 0; i < 50; i++) begin
      step(1);
      check("R9", flag_o, 1'b0, "flag while off");
      check("R9", nco_o, pol_i, "output while off");
    end
    en_i = 1'b1;
    step(200);

    // R6: sticky flag, set wins over clear
    cur_req = "R6";
    mode_i = 1'b0; inc_i = 20'h0_2000; flag_clr_i = 1'b1;
    step(3);
    flag_clr_i = 1'b0;
    step(300);
    check("R6", flag_o, 1'b1, "flag sticky");
    inc_i = 20'h8_0000; flag_clr_i = 1'b1;
    step(30);

    // R7/R8: polarity change raises the flag only with interrupts on
    cur_req = "R7";
    inc_i = '0; flag_clr_i = 1'b1;
    step(2);
    flag_clr_i = 1'b0; irq_en_i = 1'b0; pol_i = ~pol_i;
    step(2);
    check("R7", flag_o, 1'b0, "no flag, irq off");
    irq_en_i = 1'b1; pol_i = ~pol_i;
    step(2);
    check("R7", flag_o, 1'b1, "flag on pol change");
    check("R8", irq_o, 1'b1, "irq asserted");
    en_i = 1'b0;
    step(1);
    check("R8", irq_o, 1'b0, "irq gated by enable");
    en_i = 1'b1; irq_en_i = 1'b0;
    step(1);
    check("R8", irq_o, 1'b0, "irq gated by irq enable");
    flag_clr_i = 1'b1;
    step(2);
    flag_clr_i = 1'b0;

    // R10: asynchronous assert, two-edge release
    cur_req = "R10";
    pol_i = 1'b0; inc_i = 20'h8_0000; flag_clr_i = 1'b0;
    step(5);
    check("R10", flag_o, 1'b1, "flag before reset");
    #2 rst_n = 1'b0;
    #1;
    check("R10", flag_o, 1'b0, "flag cleared at once");
    check("R10", nco_o, 1'b0, "output cleared at once");
    step(2);
    rst_n = 1'b1;
    step(1);
    check("R10", flag_o, 1'b0, "still held after 1st edge");
    step(1);
    check("R10", flag_o, 1'b0, "still held after 2nd edge");
    step(1);
    check("R10", flag_o, 1'b0, "first update, acc=half");
    step(1);
    check("R10", flag_o, 1'b1, "first overflow after release");
    step(20);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule